// File: doc/BRIEF.md
# Fixed-Frame Light-Level PWM Generator

This block drives a single light-control pin with a pulse-width-modulated waveform. It runs on a fast master clock and divides time into frames of 64 clock slots (a power of two set by a width parameter). A 6-bit level value selects how many slots of each frame are high: the count is always one more than the level. Level 0 still produces a short pulse. Only the separate enable input gives a dark output. With a 13 MHz clock, the frame rate is 203.125 kHz.

The level and the enable are captured only at frame boundaries, so a frame in progress never carries a mixed duty cycle. Clearing the enable darkens the pin on the next cycle. The pin is registered. Its waveform starts each frame with the high slots and ends it with the low slots. An asynchronous active-low reset clears the block, and its release is synchronized inside the block.

Top module: `light_pwm64`

## Requirements
- R1: While `rst_n` is low, `pwm_o` is low, and it goes low as soon as `rst_n` falls without waiting for a clock edge. After release, the output stays low until a frame starts with the enable set.
- R2: Each frame lasts exactly 64 clock cycles. At level 0, successive high pulses on `pwm_o` are 64 cycles apart.
- R3: For each level N from 0 to 63, a frame has N+1 high cycles followed by 63-N low cycles. The high cycles are the first ones of the frame, slot 0 through slot N.
- R4: At level 0 with the enable set, each frame has one high cycle (slot 0) and 63 low cycles.
- R5: At level 63 with the enable set, `pwm_o` stays high in every cycle, across frame boundaries as well.
- R6: When `enable_i` is low at a clock edge, `pwm_o` is low after that edge, and it stays low for as long as `enable_i` is low.
- R7: A change of `level_i` during a frame leaves the rest of that frame unchanged. The new value governs the frame after it. The level is captured at the edge that ends slot 63.
- R8: A rise of `enable_i` during a frame leaves the rest of that frame low. Pulses resume at slot 0 of the next frame, so no partial frame is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; one frame slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| enable_i | input | 1 | Light enable; low forces the output low |
| level_i | input | 6 | Light level N, giving N+1 high slots per frame |
| pwm_o | output | 1 | Registered PWM light output |

## Verification
The bench builds the block with its default parameters: a 6-bit slot width, which gives 64 slots, and a two-stage reset synchronizer. At this size every level value can be swept, and each level gets a whole frame compared slot by slot against the rule "high while slot ≤ level". The bench locks onto the frame phase from the single pulse that level 0 produces. From that phase it places level and enable changes at chosen slots, which lets it check frame-boundary capture, immediate disable and delayed enable at exact cycles.

// File: rtl/lpwm_pkg.sv
package lpwm_pkg;

  localparam int unsigned LPWM_SLOT_W_DEF      = 6;
  localparam int unsigned LPWM_SYNC_STAGES_DEF = 2;

  // A slot is lit when its index does not exceed the programmed level.
  function automatic logic lpwm_slot_lit(input logic [15:0] slot_idx,
                                         input logic [15:0] level_val);
    return (slot_idx <= level_val);
  endfunction

endpackage

// File: rtl/lpwm_rst_sync.sv
module lpwm_rst_sync #(
  parameter int unsigned STAGES = lpwm_pkg::LPWM_SYNC_STAGES_DEF
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/lpwm_slot_ctr.sv
module lpwm_slot_ctr #(
  parameter int unsigned SLOT_W = lpwm_pkg::LPWM_SLOT_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot_o,
  output logic              last_o
);

  localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

  logic [SLOT_W-1:0] slot_d;

  assign last_o = (slot_o == SLOT_MAX);

  always_comb begin
    if (last_o) slot_d = '0;
    else        slot_d = slot_o + SLOT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_o <= '0;
    else        slot_o <= slot_d;
  end

endmodule

// File: rtl/lpwm_frame_latch.sv
module lpwm_frame_latch #(
  parameter int unsigned SLOT_W = lpwm_pkg::LPWM_SLOT_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [SLOT_W-1:0] level_i,
  input  logic              enable_i,
  output logic [SLOT_W-1:0] level_q,
  output logic              enable_q
);

  logic [SLOT_W-1:0] level_d;
  logic              enable_d;

  always_comb begin
    level_d  = level_q;
    enable_d = enable_q;
    if (load_i) begin
      level_d  = level_i;
      enable_d = enable_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q  <= '0;
      enable_q <= 1'b0;
    end else begin
      level_q  <= level_d;
      enable_q <= enable_d;
    end
  end

endmodule

// File: rtl/lpwm_out_stage.sv
module lpwm_out_stage #(
  parameter int unsigned SLOT_W = lpwm_pkg::LPWM_SLOT_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [SLOT_W-1:0] level_q,
  input  logic              enable_q,
  input  logic              enable_live,
  output logic              pwm_o
);

  logic pwm_d;
  logic lit;

  always_comb begin
    lit   = lpwm_pkg::lpwm_slot_lit(16'(slot_i), 16'(level_q));
    pwm_d = enable_live & enable_q & lit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_o <= 1'b0;
    else        pwm_o <= pwm_d;
  end

endmodule

// File: rtl/light_pwm64.sv
module light_pwm64 #(
  parameter int unsigned SLOT_W      = lpwm_pkg::LPWM_SLOT_W_DEF,
  parameter int unsigned SYNC_STAGES = lpwm_pkg::LPWM_SYNC_STAGES_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic [SLOT_W-1:0] level_i,
  output logic              pwm_o
);

  logic              rst_sync_n;
  logic [SLOT_W-1:0] slot;
  logic              frame_last;
  logic [SLOT_W-1:0] lvl_q;
  logic              en_q;
  logic              pwm_int;

  lpwm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lpwm_slot_ctr #(.SLOT_W(SLOT_W)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .slot_o (slot),
    .last_o (frame_last)
  );

  lpwm_frame_latch #(.SLOT_W(SLOT_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_i   (frame_last),
    .level_i  (level_i),
    .enable_i (enable_i),
    .level_q  (lvl_q),
    .enable_q (en_q)
  );

  lpwm_out_stage #(.SLOT_W(SLOT_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .slot_i      (slot),
    .level_q     (lvl_q),
    .enable_q    (en_q),
    .enable_live (enable_i),
    .pwm_o       (pwm_int)
  );

  assign pwm_o = pwm_int;

endmodule

// File: rtl/lpwm_checker.sv
module lpwm_checker #(
  parameter int unsigned SLOT_W = lpwm_pkg::LPWM_SLOT_W_DEF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable_i,
  input logic              pwm_o,
  input logic [SLOT_W-1:0] slot,
  input logic [SLOT_W-1:0] lvl_q,
  input logic              en_q
);

  localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

  // R2: slot index advances by one per cycle
  p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot != SLOT_MAX) |=> (slot == $past(slot) + SLOT_W'(1)));

  // R2: frame wraps after the last slot
  p_slot_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == SLOT_MAX) |=> (slot == '0));

  // R6: a low enable darkens the pin after the edge
  p_off_now_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !pwm_o);

  // R7: captured level only moves at the frame boundary
  p_lvl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot != '0) |-> $stable(lvl_q));

  // R5: full level keeps the pin lit
  p_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && en_q && lvl_q == SLOT_MAX) |=> pwm_o);

  // R4: level zero lights slot 0 only
  p_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && en_q && lvl_q == '0 && slot != '0) |=> !pwm_o);

endmodule

bind light_pwm64 lpwm_checker #(.SLOT_W(SLOT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .enable_i (enable_i),
  .pwm_o    (pwm_o),
  .slot     (slot),
  .lvl_q    (lvl_q),
  .en_q     (en_q)
);

// File: tb/sim_light_pwm64.sv
`timescale 1ns/1ps
module sim_light_pwm64;

  logic       clk;
  logic       rst_n;
  logic       enable_i;
  logic [5:0] level_i;
  logic       pwm_o;

  int checks = 0;
  int fails  = 0;
  int p      = 0;   // slot index represented by pwm_o after the latest edge
  bit done   = 0;

  light_pwm64 u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_i (enable_i),
    .level_i  (level_i),
    .pwm_o    (pwm_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
    p = (p + 1) % 64;
  endtask

  task automatic goto_slot(input int target);
    tick();
    while (p != target) tick();
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Samples one frame starting at slot 0; call when p == 63.
  task automatic sample_frame(input int lvl, output int highs, output int mism);
    highs = 0;
    mism  = 0;
    for (int s = 0; s < 64; s++) begin
      tick();
      if (pwm_o) highs++;
      if (pwm_o !== (p <= lvl)) mism++;
    end
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    int highs;
    int mism;
    int cnt;
    bit synced;
    rst_n    = 1'b1;
    enable_i = 1'b0;
    level_i  = '0;
    #2 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: output low while reset held
    check(pwm_o == 1'b0, "R1 reset low", int'(pwm_o), 0);

    rst_n    = 1'b1;
    enable_i = 1'b1;
    level_i  = 6'd0;

    // lock onto the frame phase from the first level-0 pulse
    synced = 0;
    for (int i = 0; i < 300 && !synced; i++) begin
      @(posedge clk);
      #1;
      if (pwm_o) synced = 1;
    end
    check(synced, "R1 output starts at frame after release", int'(synced), 1);
    p = 0;

    // R2 / R4: one pulse per frame, 64 cycles apart
    highs = 0;
    for (int s = 0; s < 64; s++) begin
      tick();
      if (pwm_o) highs++;
    end
    check(pwm_o == 1'b1 && p == 0, "R2 pulse period 64", int'(pwm_o), 1);
    check(highs == 1, "R4 single high slot at level 0", highs, 1);

    // R3: sweep every level over a full frame
    for (int lvl = 0; lvl < 64; lvl++) begin
      goto_slot(30);
      level_i = 6'(lvl);
      goto_slot(63);
      sample_frame(lvl, highs, mism);
      check(mism == 0, $sformatf("R3 pattern level %0d mismatches", lvl), mism, 0);
      check(highs == lvl + 1, $sformatf("R3 high count level %0d", lvl), highs, lvl + 1);
    end

    // R5: level 63 stays high over two frames (level already 63)
    goto_slot(63);
    cnt = 0;
    for (int s = 0; s < 128; s++) begin
      tick();
      if (pwm_o) cnt++;
    end
    check(cnt == 128, "R5 continuous high", cnt, 128);

    // R7: mid-frame level change does not touch the current frame
    goto_slot(5);
    level_i = 6'd0;
    cnt = 0;
    for (int s = 6; s < 64; s++) begin
      tick();
      if (pwm_o) cnt++;
    end
    check(cnt == 58, "R7 rest of frame keeps old level", cnt, 58);
    sample_frame(0, highs, mism);
    check(highs == 1 && mism == 0, "R7 new level in next frame", highs, 1);

    // R6: immediate disable
    goto_slot(30);
    level_i = 6'd40;
    goto_slot(9);
    enable_i = 1'b0;
    tick();
    check(pwm_o == 1'b0, "R6 low after enable drops", int'(pwm_o), 0);
    cnt = 0;
    for (int s = 0; s < 100; s++) begin
      tick();
      if (pwm_o) cnt++;
    end
    check(cnt == 0, "R6 stays low while disabled", cnt, 0);

    // R8: enable rises mid-frame, takes effect at next frame
    goto_slot(10);
    enable_i = 1'b1;
    cnt = 0;
    while (p != 63) begin
      tick();
      if (pwm_o) cnt++;
    end
    check(cnt == 0, "R8 no partial frame after enable", cnt, 0);
    sample_frame(40, highs, mism);
    check(highs == 41 && mism == 0, "R8 full frame after enable", highs, 41);

    // R1: asynchronous reset darkens the pin without a clock edge
    goto_slot(30);
    level_i = 6'd63;
    goto_slot(20);
    check(pwm_o == 1'b1, "R5 lit before reset", int'(pwm_o), 1);
    rst_n = 1'b0;
    #1;
    check(pwm_o == 1'b0, "R1 async reset low", int'(pwm_o), 0);
    repeat (4) @(posedge clk);
    #1;
    check(pwm_o == 1'b0, "R1 low during held reset", int'(pwm_o), 0);

    done = 1;
    report();
  end

endmodule